// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes an 8-bit processor with 16-bit addresses into an interrupt handler. While no instruction is running, it watches two request sources. One is a level-sensitive maskable request that the interrupt-disable flag can block. The other is a non-maskable request; its rising edges are captured and held until they are serviced. When it accepts a request, the block takes over the memory port. It saves the return address and the status byte on the hardware stack in page one, reads the 16-bit handler address from the fixed vector pair that belongs to the request, and then hands the processor a new program counter, stack pointer and status byte in a single completion cycle.

Every memory access takes one cycle. From the cycle after acceptance to completion, an entry occupies six cycles: three stack writes, two vector reads and one load cycle. The surrounding processor holds its own state while `active` is high. It copies `pc_new`, `sp_new` and `stat_new` into its registers in the cycle in which `done` pulses.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is only accepted in a cycle with `insn_busy` low and no entry under way. While `insn_busy` is high, `active` stays low whatever the request inputs do.
- R2: The maskable request `mreq` is level-sensitive. It is ignored while status bit 2 (interrupt disable) of `stat_cur` is set. When that bit is clear and the request is held high at a boundary, `active` rises on the next cycle.
- R3: A rising edge on `nmreq` is latched, even while `insn_busy` is high, and is serviced regardless of status bit 2. Each edge yields exactly one entry, however long the line stays high. `active` rises two cycles after the edge when the processor is idle.
- R4: When a latched non-maskable request and an enabled maskable request are both present at the same boundary, the non-maskable one is serviced and uses its own vector.
- R5: The three cycles after acceptance are stack writes with `mem_we` high, in this order: PC[15:8] to 0x0100+SP, PC[7:0] to 0x0100+SP-1, then the unmodified status byte to 0x0100+SP-2. The low address byte wraps within page 0x01.
- R6: The next two cycles are reads with `mem_re` high. The maskable entry reads 0xFFFE then 0xFFFF. The non-maskable entry reads 0xFFFA then 0xFFFB. The first byte read is the low half of the handler address.
- R7: In the sixth cycle `done` is high for exactly one cycle, with `pc_new` = {second byte, first byte}, `sp_new` = SP-3 modulo 256, and `stat_new` = status OR 0x14 (bits 2 and 4 set, all other bits unchanged).
- R8: After reset `active`, `done`, `mem_we` and `mem_re` are low. At most one of `mem_we`, `mem_re` and `done` is high in any cycle. `active` is high from the first stack write through the `done` cycle and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_busy | input | 1 | High while an instruction is executing |
| mreq | input | 1 | Maskable request, level-sensitive |
| nmreq | input | 1 | Non-maskable request, rising-edge triggered |
| pc_cur | input | 16 | Current program counter |
| sp_cur | input | 8 | Current stack pointer |
| stat_cur | input | 8 | Current status byte (bit 2 disable, bit 4 break) |
| mem_rdata | input | 8 | Read data, valid in the read cycle |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| active | output | 1 | Entry in progress; processor holds |
| done | output | 1 | Completion pulse; load the three new values |
| pc_new | output | 16 | Handler address, valid with done |
| sp_new | output | 8 | Stack pointer after three pushes, valid with done |
| stat_new | output | 8 | Status with disable and break set, valid with done |

## Verification
The bench goes after the stack-pointer wrap, where a design that carried into the page would write outside page 0x01 or return 0x01FD in place of 0xFD. It drives a non-maskable pulse while an instruction is running, to catch a design that samples the request only at the boundary and so loses the edge. It holds that line high across a whole entry, to catch a level-triggered design that enters a second time. It raises both requests at one boundary, to catch an inverted priority that would read 0xFFFE. It sets the disable flag under a held maskable request, to catch a gate that is missing or wired to the wrong status bit. The push order and the status value returned are checked byte by byte, so that swapped halves or a status pushed after modification show up.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    localparam int DW = 8;
    localparam int AW = 2 * DW;
    localparam logic [DW-1:0] STACK_PAGE   = 8'h01;
    localparam logic [AW-1:0] VEC_MASKABLE = 16'hFFFE;
    localparam logic [AW-1:0] VEC_NONMASK  = 16'hFFFA;
    localparam int BIT_I = 2;
    localparam int BIT_B = 4;
    localparam logic [DW-1:0] ENTRY_SET = DW'((1 << BIT_I) | (1 << BIT_B));

    typedef enum logic [2:0] {
        S_IDLE, S_PSH_H, S_PSH_L, S_PSH_S, S_VEC_L, S_VEC_H, S_LOAD
    } seq_state_t;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [DW-1:0] sp;
        logic [DW-1:0] st;
        logic          nm;
    } entry_ctx_t;

    function automatic logic [AW-1:0] stack_addr(input logic [DW-1:0] sp);
        return {STACK_PAGE, sp};
    endfunction

    function automatic logic [AW-1:0] vec_base(input logic nm);
        return nm ? VEC_NONMASK : VEC_MASKABLE;
    endfunction
endpackage

// File: rtl/irq_nm_latch.sv
module irq_nm_latch (
    input  logic clk,
    input  logic rst,
    input  logic nm_in,
    input  logic clear,
    output logic pend
);
    logic prev_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= nm_in;
            pend   <= (pend & ~clear) | (nm_in & ~prev_q);
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter (
    input  logic idle,
    input  logic insn_busy,
    input  logic nm_pend,
    input  logic mreq,
    input  logic mask_flag,
    output logic take,
    output logic take_nm
);
    logic boundary;
    always_comb begin
        boundary = idle & ~insn_busy;
        take_nm  = boundary & nm_pend;
        take     = take_nm | (boundary & mreq & ~mask_flag);
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          insn_busy,
    input  logic          mreq,
    input  logic          nmreq,
    input  logic [AW-1:0] pc_cur,
    input  logic [DW-1:0] sp_cur,
    input  logic [DW-1:0] stat_cur,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    output logic          active,
    output logic          done,
    output logic [AW-1:0] pc_new,
    output logic [DW-1:0] sp_new,
    output logic [DW-1:0] stat_new
);
    seq_state_t    state_q;
    entry_ctx_t    ctx_q;
    logic [DW-1:0] vec_lo_q, vec_hi_q;
    logic          nm_pend, take, take_nm, idle;

    assign idle = (state_q == S_IDLE);

    irq_nm_latch u_nm (
        .clk   (clk),
        .rst   (rst),
        .nm_in (nmreq),
        .clear (take_nm),
        .pend  (nm_pend)
    );

    irq_arbiter u_arb (
        .idle      (idle),
        .insn_busy (insn_busy),
        .nm_pend   (nm_pend),
        .mreq      (mreq),
        .mask_flag (stat_cur[BIT_I]),
        .take      (take),
        .take_nm   (take_nm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            ctx_q    <= '0;
            vec_lo_q <= '0;
            vec_hi_q <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (take) begin
                    ctx_q   <= '{pc: pc_cur, sp: sp_cur, st: stat_cur, nm: take_nm};
                    state_q <= S_PSH_H;
                end
                S_PSH_H: begin
                    ctx_q.sp <= ctx_q.sp - DW'(1);
                    state_q  <= S_PSH_L;
                end
                S_PSH_L: begin
                    ctx_q.sp <= ctx_q.sp - DW'(1);
                    state_q  <= S_PSH_S;
                end
                S_PSH_S: begin
                    ctx_q.sp <= ctx_q.sp - DW'(1);
                    state_q  <= S_VEC_L;
                end
                S_VEC_L: begin
                    vec_lo_q <= mem_rdata;
                    state_q  <= S_VEC_H;
                end
                S_VEC_H: begin
                    vec_hi_q <= mem_rdata;
                    state_q  <= S_LOAD;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        done      = 1'b0;
        case (state_q)
            S_PSH_H: begin
                mem_we    = 1'b1;
                mem_addr  = stack_addr(ctx_q.sp);
                mem_wdata = ctx_q.pc[AW-1:DW];
            end
            S_PSH_L: begin
                mem_we    = 1'b1;
                mem_addr  = stack_addr(ctx_q.sp);
                mem_wdata = ctx_q.pc[DW-1:0];
            end
            S_PSH_S: begin
                mem_we    = 1'b1;
                mem_addr  = stack_addr(ctx_q.sp);
                mem_wdata = ctx_q.st;
            end
            S_VEC_L: begin
                mem_re   = 1'b1;
                mem_addr = vec_base(ctx_q.nm);
            end
            S_VEC_H: begin
                mem_re   = 1'b1;
                mem_addr = vec_base(ctx_q.nm) + AW'(1);
            end
            S_LOAD:  done = 1'b1;
            default: ;
        endcase
    end

    assign active   = ~idle;
    assign pc_new   = {vec_hi_q, vec_lo_q};
    assign sp_new   = ctx_q.sp;
    assign stat_new = ctx_q.st | ENTRY_SET;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
    import irq_seq_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          insn_busy,
    input logic [DW-1:0] stat_cur,
    input logic          nm_pend,
    input logic          active,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic [DW-1:0] stat_new
);
    a_r1_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        (!active && insn_busy) |=> !active);

    a_r2_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        (!active && !insn_busy && !nm_pend && stat_cur[BIT_I]) |=> !active);

    a_r3_nm_unmaskable: assert property (@(posedge clk) disable iff (rst)
        (!active && !insn_busy && nm_pend) |=> active);

    a_r5_stack_page: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[AW-1:DW] == STACK_PAGE));

    a_r6_vector_region: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> (mem_addr[AW-1:3] == 13'h1FFF));

    a_r7_flags_set: assert property (@(posedge clk) disable iff (rst)
        done |-> (stat_new[BIT_I] && stat_new[BIT_B]));

    a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, mem_re, done}));

    a_r8_done_after_read: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_re));

    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !active);
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .insn_busy (insn_busy),
    .stat_cur  (stat_cur),
    .nm_pend   (nm_pend),
    .active    (active),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .done      (done),
    .stat_new  (stat_new)
);

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_busy = 1'b0;
    logic        mreq = 1'b0;
    logic        nmreq = 1'b0;
    logic [15:0] pc_cur = 16'h0;
    logic [7:0]  sp_cur = 8'h0;
    logic [7:0]  stat_cur = 8'h0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_re, active, done;
    logic [15:0] pc_new;
    logic [7:0]  sp_new, stat_new;
    logic [15:0] irq_vec = 16'h0;
    logic [15:0] nm_vec = 16'h0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    always_comb begin
        case (mem_addr)
            16'hFFFE: mem_rdata = irq_vec[7:0];
            16'hFFFF: mem_rdata = irq_vec[15:8];
            16'hFFFA: mem_rdata = nm_vec[7:0];
            16'hFFFB: mem_rdata = nm_vec[15:8];
            default:  mem_rdata = 8'hEE;
        endcase
    end

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst(rst), .insn_busy(insn_busy), .mreq(mreq), .nmreq(nmreq),
        .pc_cur(pc_cur), .sp_cur(sp_cur), .stat_cur(stat_cur), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .active(active), .done(done), .pc_new(pc_new), .sp_new(sp_new), .stat_new(stat_new)
    );

    // {nm, pc, sp, status, handler address}
    localparam int NV = 6;
    localparam logic [48:0] VECS [NV] = '{
        {1'b0, 16'h1234, 8'hFF, 8'h00, 16'h8000},
        {1'b1, 16'hABCD, 8'h80, 8'h04, 16'hC000},
        {1'b0, 16'h00FF, 8'h01, 8'hC3, 16'h1FFE},
        {1'b1, 16'hFFFF, 8'h00, 8'h20, 16'h0000},
        {1'b0, 16'h8001, 8'h42, 8'h18, 16'hE5A7},
        {1'b0, 16'h5A5A, 8'hFD, 8'h80, 16'h0102}
    };

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_entry(input logic nm, input logic [15:0] pc, input logic [7:0] sp,
                             input logic [7:0] st, input logic [15:0] vec);
        logic [15:0] base;
        int lat;
        base = nm ? 16'hFFFA : 16'hFFFE;
        if (nm) begin nm_vec = vec; irq_vec = 16'h5A5A; end
        else    begin irq_vec = vec; nm_vec = 16'hA5A5; end
        pc_cur = pc; sp_cur = sp; stat_cur = st; insn_busy = 1'b0;
        if (nm) nmreq = 1'b1; else mreq = 1'b1;
        lat = 0;
        while (lat < 4) begin
            @(negedge clk);
            lat++;
            nmreq = 1'b0;
            if (active) break;
        end
        mreq = 1'b0;
        cmp(nm ? "R3 latency" : "R2 latency", 32'(lat), nm ? 32'd2 : 32'd1);
        cmp("R5 push pc high", {6'd0, mem_we, mem_re, mem_addr, mem_wdata},
            {6'd0, 2'b10, 8'h01, sp, pc[15:8]});
        @(negedge clk);
        cmp("R5 push pc low", {6'd0, mem_we, mem_re, mem_addr, mem_wdata},
            {6'd0, 2'b10, 8'h01, 8'(sp - 8'd1), pc[7:0]});
        @(negedge clk);
        cmp("R5 push status", {6'd0, mem_we, mem_re, mem_addr, mem_wdata},
            {6'd0, 2'b10, 8'h01, 8'(sp - 8'd2), st});
        @(negedge clk);
        cmp("R6 vector low read", {14'd0, mem_we, mem_re, mem_addr}, {14'd0, 2'b01, base});
        @(negedge clk);
        cmp("R6 vector high read", {14'd0, mem_we, mem_re, mem_addr},
            {14'd0, 2'b01, 16'(base + 16'd1)});
        @(negedge clk);
        cmp("R7 done and pc", {14'd0, done, active, pc_new}, {14'd0, 2'b11, vec});
        cmp("R7 sp and status", {16'd0, sp_new, stat_new},
            {16'd0, 8'(sp - 8'd3), st | 8'h14});
        @(negedge clk);
        cmp("R8 idle after done", {30'd0, done, active}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp("R8 reset outputs", {28'd0, active, done, mem_we, mem_re}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        cmp("R8 idle after reset", {30'd0, active, mem_we}, 32'd0);

        for (int k = 0; k < NV; k++) begin
            run_entry(VECS[k][48], VECS[k][47:32], VECS[k][31:24], VECS[k][23:16], VECS[k][15:0]);
            repeat (2) @(negedge clk);
        end

        // R2: disable flag blocks a held maskable request
        stat_cur = 8'h04; mreq = 1'b1; insn_busy = 1'b0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            cmp("R2 masked request ignored", {30'd0, active, mem_we}, 32'd0);
        end
        mreq = 1'b0; stat_cur = 8'h00;
        @(negedge clk);

        // R1 + R3 + R4: edge during busy is latched; both pending -> non-maskable wins
        insn_busy = 1'b1; mreq = 1'b1; nm_vec = 16'h4321; irq_vec = 16'h9999;
        pc_cur = 16'h2468; sp_cur = 8'hF0;
        nmreq = 1'b1;
        @(negedge clk);
        nmreq = 1'b0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            cmp("R1 no entry while busy", {31'd0, active}, 32'd0);
        end
        insn_busy = 1'b0;
        @(negedge clk);
        mreq = 1'b0;
        cmp("R1 entry at boundary", {31'd0, active}, 32'd1);
        repeat (3) @(negedge clk);
        cmp("R4 non-maskable vector chosen", {15'd0, mem_re, mem_addr}, {15'd0, 1'b1, 16'hFFFA});
        repeat (2) @(negedge clk);
        cmp("R4 handler address", {15'd0, done, pc_new}, {15'd0, 1'b1, 16'h4321});
        repeat (2) @(negedge clk);

        // R3: a line held high gives one entry only
        stat_cur = 8'h04;
        nmreq = 1'b1;
        repeat (2) @(negedge clk);
        cmp("R3 held line enters", {31'd0, active}, 32'd1);
        repeat (6) @(negedge clk);
        for (int c = 0; c < 6; c++) begin
            cmp("R3 no second entry", {30'd0, active, mem_we}, 32'd0);
            @(negedge clk);
        end
        nmreq = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule